// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block holds a small number of recently used page translations and answers lookups in the cycle they are presented. A lookup supplies a full virtual address. The block splits the virtual page number into two fields. The low field picks one set. The high field is compared against the tags of every way in that set. On a hit the stored physical page number is placed in front of the untouched page offset, so the physical address is ready with no memory access. The stored permission bits are returned alongside it. On a miss the block raises a miss flag, so that an external walker can fetch the translation.

When the walker has resolved a translation, it installs the result through the fill port. The destination way within the set is chosen in a fixed order:
- a way that already holds the same tag is rewritten;
- otherwise the lowest-numbered empty way is used;
- otherwise the way named by that set's round-robin pointer is replaced.

A single-cycle flush input empties the whole array, for example on an address-space switch.

The default configuration is as follows:
- The virtual address is 14 bits and the physical address is 12 bits.
- Pages are 64 bytes, giving an 8-bit virtual page number and a 6-bit physical page number.
- There are 16 entries, arranged as 4 sets of 4 ways.

Top module: `xlat_cache`

## Requirements
- R1: After reset every lookup misses: `lk_hit`=0, `lk_paddr`=0 and `lk_perm`=0.
- R2: The set index is VA[7:6] and the tag is VA[13:8]. A lookup hits only if a valid entry in the indexed set holds an equal tag. Hit, address and permission outputs are combinational in the same cycle as the lookup.
- R3: On a hit, `lk_paddr` = {stored PPN, VA[5:0]}. On a miss, `lk_paddr` and `lk_perm` are 0. `lk_miss` = `lk_valid` AND NOT `lk_hit`. With `lk_valid`=0, both `lk_hit` and `lk_miss` are 0.
- R4: A fill is visible to lookups from the next cycle on. A lookup in the same cycle as the fill sees the old contents.
- R5: A fill into a set that has an empty way writes the lowest-numbered empty way. The set's pointer does not move.
- R6: Each set has its own 2-bit replacement pointer, which starts at 0. A fill into a full set with no matching tag replaces the pointed way. The pointer then advances by one, wrapping from 3 to 0.
- R7: A fill whose tag already sits in a valid way of its set rewrites that way's PPN and permissions. No second copy is made and the pointer does not move.
- R8: `inv_all` empties every entry and returns every pointer to 0, effective from the next cycle. A fill presented in the same cycle is discarded.
- R9: The 3-bit permission field given on fill is returned unchanged by every hit on that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request present but no translation found |
| lk_paddr | output | 12 | Physical address on hit, 0 otherwise |
| lk_perm | output | 3 | Permission bits on hit, 0 otherwise |
| fl_valid | input | 1 | Install a translation |
| fl_vpn | input | 8 | Virtual page number being installed |
| fl_ppn | input | 6 | Physical page number being installed |
| fl_perm | input | 3 | Permission bits being installed |
| inv_all | input | 1 | Flush every entry and pointer |

## Verification
The bench keeps a behavioural model of the array and sweeps all 256 page numbers after each phase of fills. Each sweep uses a different page offset per lookup.

The phases are chosen to catch specific errors:
- A design that wrote the wrong empty way, or that advanced the pointer on a non-evicting fill, would evict the wrong tag at the fifth fill into a set. A later sweep would then show one entry missing and another present.
- A design with a shared pointer across sets would evict the wrong way once two sets have been filled in turn.
- A design that allocated a fresh way on a repeated page number would show the stale physical page, or lose a neighbour.
- A design that let a fill slip past a simultaneous flush, or kept the old pointers after a flush, would show up in the sweep that follows the flush.

Lookups made in the same cycle as a fill expose a write that leaks into the current cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned XLAT_VA_W   = 14;
    localparam int unsigned XLAT_OFF_W  = 6;
    localparam int unsigned XLAT_PPN_W  = 6;
    localparam int unsigned XLAT_PERM_W = 3;
    localparam int unsigned XLAT_SETS   = 4;
    localparam int unsigned XLAT_WAYS   = 4;

    // How the fill port picked its destination way
    typedef enum logic [1:0] {
        VIC_IDLE  = 2'd0,
        VIC_MATCH = 2'd1,
        VIC_FREE  = 2'd2,
        VIC_EVICT = 2'd3
    } vic_kind_e;

endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int unsigned SETS   = 4,
    parameter int unsigned WAYS   = 4,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned PPN_W  = 6,
    parameter int unsigned PERM_W = 3,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inv_all,
    input  logic                          we,
    input  logic [IDX_W-1:0]              we_set,
    input  logic [WAY_W-1:0]              we_way,
    input  logic [TAG_W-1:0]              we_tag,
    input  logic [PPN_W-1:0]              we_ppn,
    input  logic [PERM_W-1:0]             we_perm,
    input  logic [IDX_W-1:0]              a_set,
    output logic [WAYS-1:0]               a_vld,
    output logic [WAYS-1:0][TAG_W-1:0]    a_tag,
    output logic [WAYS-1:0][PPN_W-1:0]    a_ppn,
    output logic [WAYS-1:0][PERM_W-1:0]   a_perm,
    input  logic [IDX_W-1:0]              b_set,
    output logic [WAYS-1:0]               b_vld,
    output logic [WAYS-1:0][TAG_W-1:0]    b_tag
);

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [PPN_W-1:0]          ppn_q  [SETS][WAYS];
    logic [PERM_W-1:0]         perm_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (inv_all) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[we_set][we_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !inv_all) begin
            tag_q[we_set][we_way]  <= we_tag;
            ppn_q[we_set][we_way]  <= we_ppn;
            perm_q[we_set][we_way] <= we_perm;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign a_vld[w]  = vld_q[a_set][w];
        assign a_tag[w]  = tag_q[a_set][w];
        assign a_ppn[w]  = ppn_q[a_set][w];
        assign a_perm[w] = perm_q[a_set][w];
        assign b_vld[w]  = vld_q[b_set][w];
        assign b_tag[w]  = tag_q[b_set][w];
    end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned PPN_W  = 6,
    parameter int unsigned PERM_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_valid,
    input  logic [TAG_W-1:0]              lk_tag,
    input  logic [WAYS-1:0]               set_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]    set_tag,
    input  logic [WAYS-1:0][PPN_W-1:0]    set_ppn,
    input  logic [WAYS-1:0][PERM_W-1:0]   set_perm,
    output logic                          hit,
    output logic [PPN_W-1:0]              ppn,
    output logic [PERM_W-1:0]             perm
);

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = lk_valid && set_vld[w] && (set_tag[w] == lk_tag);
    end

    always_comb begin
        ppn  = '0;
        perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                ppn  = ppn  | set_ppn[w];
                perm = perm | set_perm[w];
            end
        end
    end

    assign hit = |hit_vec;

    // R7
    single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int unsigned SETS  = 4,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 6,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inv_all,
    input  logic                          fl_valid,
    input  logic [IDX_W-1:0]              fl_set,
    input  logic [TAG_W-1:0]              fl_tag,
    input  logic [WAYS-1:0]               set_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]    set_tag,
    output logic                          we,
    output logic [WAY_W-1:0]              we_way
);

    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAYS-1:0]  match_vec;
    logic [WAYS-1:0]  free_vec;
    logic [WAY_W-1:0] match_way;
    logic [WAY_W-1:0] free_way;
    vic_kind_e        kind;

    for (genvar w = 0; w < WAYS; w++) begin : g_scan
        assign match_vec[w] = set_vld[w] && (set_tag[w] == fl_tag);
        assign free_vec[w]  = !set_vld[w];
    end

    always_comb begin
        match_way = '0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) match_way = WAY_W'(w);
            if (free_vec[w])  free_way  = WAY_W'(w);
        end
    end

    always_comb begin
        if (!fl_valid || inv_all) begin
            kind = VIC_IDLE;
        end else if (|match_vec) begin
            kind = VIC_MATCH;
        end else if (|free_vec) begin
            kind = VIC_FREE;
        end else begin
            kind = VIC_EVICT;
        end
    end

    always_comb begin
        unique case (kind)
            VIC_MATCH: we_way = match_way;
            VIC_FREE:  we_way = free_way;
            VIC_EVICT: we_way = ptr_q[fl_set];
            default:   we_way = '0;
        endcase
    end

    assign we = (kind != VIC_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (kind == VIC_EVICT) begin
            ptr_q[fl_set] <= ptr_q[fl_set] + 1'b1;
        end
    end

    // R7
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> $onehot0(match_vec));

    // R5
    free_way_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(|match_vec)) |-> (!set_vld[we_way] || !(|free_vec)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned VA_W   = XLAT_VA_W,
    parameter int unsigned OFF_W  = XLAT_OFF_W,
    parameter int unsigned PPN_W  = XLAT_PPN_W,
    parameter int unsigned PERM_W = XLAT_PERM_W,
    parameter int unsigned SETS   = XLAT_SETS,
    parameter int unsigned WAYS   = XLAT_WAYS,
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = VPN_W - IDX_W,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned PA_W  = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              inv_all
);

    logic [VPN_W-1:0]               lk_vpn;
    logic [IDX_W-1:0]               lk_set;
    logic [TAG_W-1:0]               lk_tag;
    logic [IDX_W-1:0]               fl_set;
    logic [TAG_W-1:0]               fl_tag;
    logic [WAYS-1:0]                a_vld;
    logic [WAYS-1:0][TAG_W-1:0]     a_tag;
    logic [WAYS-1:0][PPN_W-1:0]     a_ppn;
    logic [WAYS-1:0][PERM_W-1:0]    a_perm;
    logic [WAYS-1:0]                b_vld;
    logic [WAYS-1:0][TAG_W-1:0]     b_tag;
    logic                           we;
    logic [WAY_W-1:0]               we_way;
    logic                           m_hit;
    logic [PPN_W-1:0]               m_ppn;
    logic [PERM_W-1:0]              m_perm;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_set = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_set = fl_vpn[IDX_W-1:0];
    assign fl_tag = fl_vpn[VPN_W-1:IDX_W];

    xlat_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_all (inv_all),
        .we      (we),
        .we_set  (fl_set),
        .we_way  (we_way),
        .we_tag  (fl_tag),
        .we_ppn  (fl_ppn),
        .we_perm (fl_perm),
        .a_set   (lk_set),
        .a_vld   (a_vld),
        .a_tag   (a_tag),
        .a_ppn   (a_ppn),
        .a_perm  (a_perm),
        .b_set   (fl_set),
        .b_vld   (b_vld),
        .b_tag   (b_tag)
    );

    xlat_victim #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_all  (inv_all),
        .fl_valid (fl_valid),
        .fl_set   (fl_set),
        .fl_tag   (fl_tag),
        .set_vld  (b_vld),
        .set_tag  (b_tag),
        .we       (we),
        .we_way   (we_way)
    );

    xlat_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .set_vld  (a_vld),
        .set_tag  (a_tag),
        .set_ppn  (a_ppn),
        .set_perm (a_perm),
        .hit      (m_hit),
        .ppn      (m_ppn),
        .perm     (m_perm)
    );

    assign lk_hit   = m_hit;
    assign lk_miss  = lk_valid && !m_hit;
    assign lk_paddr = m_hit ? {m_ppn, lk_vaddr[OFF_W-1:0]} : '0;
    assign lk_perm  = m_perm;

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_valid) && !$past(inv_all) && lk_valid && (lk_vpn == $past(fl_vpn)))
        |-> (lk_hit && (lk_paddr[PA_W-1:OFF_W] == $past(fl_ppn))
                    && (lk_perm == $past(fl_perm))));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit);

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [13:0] lk_vaddr = '0;
    logic        lk_hit;
    logic        lk_miss;
    logic [11:0] lk_paddr;
    logic [2:0]  lk_perm;
    logic        fl_valid = 1'b0;
    logic [7:0]  fl_vpn = '0;
    logic [5:0]  fl_ppn = '0;
    logic [2:0]  fl_perm = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int failures = 0;

    bit mv    [4][4];
    int mtag  [4][4];
    int mppn  [4][4];
    int mperm [4][4];
    int mptr  [4];

    always #(CLK_P/2) clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_perm(fl_perm),
        .inv_all(inv_all)
    );

    task automatic model_clear();
        for (int s = 0; s < 4; s++) begin
            mptr[s] = 0;
            for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        end
    endtask

    task automatic model_fill(int vpn, int ppn, int perm);
        int s = vpn % 4;
        int t = vpn / 4;
        int way = -1;
        for (int w = 3; w >= 0; w--) if (mv[s][w] && mtag[s][w] == t) way = w;
        if (way < 0) for (int w = 3; w >= 0; w--) if (!mv[s][w]) way = w;
        if (way < 0) begin
            way = mptr[s];
            mptr[s] = (mptr[s] + 1) % 4;
        end
        mv[s][way] = 1'b1;
        mtag[s][way] = t;
        mppn[s][way] = ppn;
        mperm[s][way] = perm;
    endtask

    task automatic check_lk(string req, bit lv, int va);
        int s = (va >> 6) % 4;
        int t = (va >> 8) & 63;
        bit eh = 1'b0;
        int ep = 0;
        int er = 0;
        int ea;
        for (int w = 0; w < 4; w++)
            if (lv && mv[s][w] && mtag[s][w] == t) begin
                eh = 1'b1; ep = mppn[s][w]; er = mperm[s][w];
            end
        ea = eh ? ((ep << 6) | (va & 63)) : 0;
        checks++;
        if (lk_hit !== eh || lk_miss !== (lv && !eh) ||
            lk_paddr !== 12'(ea) || lk_perm !== 3'(er)) begin
            failures++;
            $display("FAIL %s va=%h actual hit=%b miss=%b pa=%h perm=%h expected hit=%b miss=%b pa=%h perm=%h",
                     req, va, lk_hit, lk_miss, lk_paddr, lk_perm, eh, lv && !eh, ea, er);
        end
    endtask

    task automatic tick(string req, bit fv, int fvpn, int fppn, int fperm,
                        bit inv, bit lv, int lva);
        @(negedge clk);
        fl_valid = fv; fl_vpn = 8'(fvpn); fl_ppn = 6'(fppn); fl_perm = 3'(fperm);
        inv_all = inv; lk_valid = lv; lk_vaddr = 14'(lva);
        #2;
        check_lk(req, lv, lva);
        @(posedge clk);
        if (inv) model_clear();
        else if (fv) model_fill(fvpn, fppn, fperm);
    endtask

    task automatic sweep(string req, int salt);
        for (int v = 0; v < 256; v++)
            tick(req, 1'b0, 0, 0, 0, 1'b0, 1'b1, (v << 6) | ((v * 7 + salt) & 63));
        tick(req, 1'b0, 0, 0, 0, 1'b0, 1'b0, 14'h3FFF);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, all pages miss; R3 zeroed outputs
        sweep("R1", 3);

        // R4 same-cycle lookup of the page being filled sees old (miss)
        tick("R4", 1'b1, 8'h04, 6'h11, 1, 1'b0, 1'b1, (8'h04 << 6) | 5);
        tick("R4", 1'b1, 8'h08, 6'h12, 2, 1'b0, 1'b1, (8'h04 << 6) | 9);
        // R5 fill the remaining free ways of set 0
        tick("R5", 1'b1, 8'h0C, 6'h13, 3, 1'b0, 1'b0, 0);
        tick("R5", 1'b1, 8'h10, 6'h14, 4, 1'b0, 1'b0, 0);
        sweep("R2", 11);

        // R6 evictions in set 0 follow pointer 0,1,2; set 1 independent
        tick("R6", 1'b1, 8'h14, 6'h21, 5, 1'b0, 1'b0, 0);
        tick("R6", 1'b1, 8'h18, 6'h22, 6, 1'b0, 1'b0, 0);
        for (int k = 0; k < 5; k++)
            tick("R6", 1'b1, 1 + 4 * (k + 1), 6'h30 + k, k, 1'b0, 1'b0, 0);
        tick("R6", 1'b1, 8'h1C, 6'h23, 7, 1'b0, 1'b0, 0);
        sweep("R6", 17);

        // R7 refill of a present page rewrites in place
        tick("R7", 1'b1, 8'h10, 6'h3E, 7, 1'b0, 1'b1, (8'h10 << 6) | 1);
        tick("R7", 1'b1, 8'h15, 6'h0A, 0, 1'b0, 1'b0, 0);
        tick("R9", 1'b1, 8'h0C, 6'h01, 6, 1'b0, 1'b0, 0);
        sweep("R7", 29);
        tick("R6", 1'b1, 8'h20, 6'h05, 2, 1'b0, 1'b0, 0);
        sweep("R6", 31);

        // R8 flush with a simultaneous fill: fill dropped, pointers cleared
        tick("R8", 1'b1, 8'h22, 6'h07, 1, 1'b1, 1'b1, (8'h10 << 6) | 2);
        sweep("R8", 41);
        for (int k = 0; k < 6; k++)
            tick("R8", 1'b1, 2 + 4 * k, 6'h08 + k, k, 1'b0, 1'b1, ((2 + 4 * k) << 6) | k);
        sweep("R8", 43);

        // R9 mixed pattern fills with interleaved lookups
        for (int k = 0; k < 120; k++)
            tick("R9", 1'b1, (k * 37 + 11) & 255, (k * 5 + 3) & 63, k & 7,
                 1'b0, 1'b1, (((k * 37 + 11 + 4 * (k % 3)) & 255) << 6) | (k & 63));
        sweep("R9", 53);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule